// File: doc/BRIEF.md
# Register Rename with Free List and Status-Only Reorder Buffer

This block sits between instruction decode and scheduling in an out-of-order core. Each cycle it can take a group of up to three micro-ops. Each micro-op names up to two source registers and at most one destination register, all drawn from an 8-entry architectural register set. The block translates every source into the 128-entry physical register space, using the speculative map. A destination gets a fresh physical register from a free pool, and that register can be any free one, not the next in a sequence. Each valid micro-op also gets the next reorder-buffer slot. The slot index is the micro-op's age tag. Reorder-buffer slots record only a completion flag and the bookkeeping needed to undo or commit the mapping. No result value is stored, so nothing is copied when a micro-op commits.

The rename group uses a valid/ready handshake. `in_ready` reflects whether the slots marked valid can all be served at once, and it may depend on the group's content. A group transfers only in a cycle where both `in_valid` and `in_ready` are high, and the whole group transfers together. The `out_*` values belong to the current group and are meaningful in that cycle only. The sender keeps the group stable while `in_ready` is low.

Completion is a plain one-tag-per-cycle strobe. Commit runs by itself from the oldest slot, up to three per cycle. When a micro-op with a destination commits, the physical register its destination held before renaming goes back to the pool. The committed map is updated at the same time. A flush throws away everything in flight. It restores the speculative map from the committed map and rebuilds the pool from it.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register a maps to physical register a in both maps, physical registers 8..127 are free, the reorder buffer is empty, and `ret_cnt` is 0.
- R2: A source is translated through the speculative map. If an older valid slot of the same group writes that architectural register, the source takes the physical register given to the youngest such older slot instead.
- R3: Slots that are valid and have a destination receive the lowest-numbered free physical registers, in increasing order by slot index. `out_pold` gives the destination's previous mapping, and the same bypass as R2 applies to it.
- R4: Valid slots get consecutive reorder-buffer tags starting at the tail, in slot order, wrapping modulo 32. Tags are not given to invalid slots.
- R5: `in_ready` is low when the number of valid slots exceeds the free reorder-buffer slots (32 minus occupancy), when the number of destinations exceeds the free physical registers, or when `flush` is high. Otherwise it is high.
- R6: A completion marks its tag done from the next cycle onward. `ret_cnt` reports how many of the oldest entries (at most 3) are done in an unbroken run starting at the head, and those entries leave the buffer at the edge.
- R7: A committing entry with a destination returns its previous physical register to the pool and can be handed out again from the following cycle. Its new register becomes the committed mapping.
- R8: While `flush` is high nothing commits. At the edge, the speculative map becomes the committed map, the pool becomes every physical register not held by the committed map, and the buffer empties.
- R9: Slots whose valid bit is low are ignored. They take no tag, take no register and change no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rename group present |
| in_ready | output | 1 | Group can be accepted whole this cycle |
| in_slot_v | input | 3 | Per-slot valid |
| in_has_dst | input | 3 | Per-slot destination present |
| in_src_a | input | 3x3 | First source architectural register per slot |
| in_src_b | input | 3x3 | Second source architectural register per slot |
| in_dst | input | 3x3 | Destination architectural register per slot |
| out_tag | output | 3x5 | Reorder-buffer tag per slot |
| out_psrc_a | output | 3x7 | Physical first source per slot |
| out_psrc_b | output | 3x7 | Physical second source per slot |
| out_pdst | output | 3x7 | New physical destination per slot |
| out_pold | output | 3x7 | Previous physical mapping of the destination per slot |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 5 | Tag of the completed micro-op |
| flush | input | 1 | Discard all in-flight micro-ops |
| ret_cnt | output | 2 | Number of entries committed this cycle |

## Verification
Random groups with holes in the slot mask, random destinations and random completion order check the mapping, tag and register-choice rules against a bench model. Groups that chain one architectural register through all three slots separate the in-group bypass from a plain table read. A burst with no completions drives the buffer full, which separates the occupancy check from the wrap-bit full detection. Completing that burst youngest-first holds commit back until the head is done and then shows the three-per-cycle limit. Flushes after partial commit show whether the restore uses the committed map rather than reset values.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_N = 8;
  localparam int PHYS_N = 128;
  localparam int ROB_N  = 32;
  localparam int WIDTH  = 3;
  localparam int AW = $clog2(ARCH_N);
  localparam int PW = $clog2(PHYS_N);
  localparam int RW = $clog2(ROB_N);
  localparam int CW = $clog2(WIDTH + 1);

  typedef logic [AW-1:0] areg_t;
  typedef logic [PW-1:0] preg_t;
  typedef logic [RW-1:0] rtag_t;

  typedef struct packed {
    logic  has_dst;
    areg_t adst;
    preg_t pnew;
    preg_t pold;
  } robent_t;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist import rn_pkg::*; (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [PHYS_N-1:0]        keep_mask,
  input  logic [WIDTH-1:0]         take,
  input  logic [WIDTH-1:0]         rel_v,
  input  preg_t [WIDTH-1:0]        rel_p,
  output preg_t [WIDTH-1:0]        pick,
  output logic [PW:0]              avail
);
  logic [PHYS_N-1:0] free_q, free_d;

  // lowest-numbered free registers, one per lane
  always_comb begin
    logic [PHYS_N-1:0] m;
    logic hit;
    m = free_q;
    for (int k = 0; k < WIDTH; k++) begin
      pick[k] = '0;
      hit = 1'b0;
      for (int i = 0; i < PHYS_N; i++) begin
        if (!hit && m[i]) begin
          pick[k] = preg_t'(i);
          hit = 1'b1;
        end
      end
      if (hit) m[pick[k]] = 1'b0;
    end
  end

  always_comb begin
    avail = '0;
    for (int i = 0; i < PHYS_N; i++) avail = avail + (PW+1)'(free_q[i]);
  end

  always_comb begin
    free_d = free_q;
    for (int k = 0; k < WIDTH; k++) if (take[k]) free_d[pick[k]] = 1'b0;
    for (int k = 0; k < WIDTH; k++) if (rel_v[k]) free_d[rel_p[k]] = 1'b1;
    if (flush) free_d = ~keep_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= {{(PHYS_N-ARCH_N){1'b1}}, {ARCH_N{1'b0}}};
    else        free_q <= free_d;
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_chk
    // R7: a returned register must not already be in the pool
    a_r7_no_double_free: assert property (@(posedge clk) disable iff (!rst_n)
      rel_v[k] |-> !free_q[rel_p[k]]);
    // R3: a lane is consumed only when the pool holds enough registers
    a_r3_take_avail: assert property (@(posedge clk) disable iff (!rst_n)
      take[k] |-> (avail > (PW+1)'(k)));
  end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable import rn_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  fire,
  input  logic [WIDTH-1:0]      slot_v,
  input  logic [WIDTH-1:0]      has_dst,
  input  areg_t [WIDTH-1:0]     src_a,
  input  areg_t [WIDTH-1:0]     src_b,
  input  areg_t [WIDTH-1:0]     dst,
  input  preg_t [WIDTH-1:0]     pnew,
  input  logic [WIDTH-1:0]      ret_v,
  input  areg_t [WIDTH-1:0]     ret_adst,
  input  preg_t [WIDTH-1:0]     ret_pnew,
  output preg_t [WIDTH-1:0]     psrc_a,
  output preg_t [WIDTH-1:0]     psrc_b,
  output preg_t [WIDTH-1:0]     pold,
  output logic [PHYS_N-1:0]     keep_mask
);
  preg_t smap [ARCH_N];
  preg_t rmap [ARCH_N];

  // table read with bypass from older slots of the same group
  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      psrc_a[k] = smap[src_a[k]];
      psrc_b[k] = smap[src_b[k]];
      pold[k]   = smap[dst[k]];
      for (int j = 0; j < k; j++) begin
        if (slot_v[j] && has_dst[j]) begin
          if (dst[j] == src_a[k]) psrc_a[k] = pnew[j];
          if (dst[j] == src_b[k]) psrc_b[k] = pnew[j];
          if (dst[j] == dst[k])   pold[k]   = pnew[j];
        end
      end
    end
  end

  always_comb begin
    keep_mask = '0;
    for (int a = 0; a < ARCH_N; a++) keep_mask[rmap[a]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_N; a++) begin
        smap[a] <= preg_t'(a);
        rmap[a] <= preg_t'(a);
      end
    end else begin
      if (flush) begin
        for (int a = 0; a < ARCH_N; a++) smap[a] <= rmap[a];
      end else if (fire) begin
        for (int k = 0; k < WIDTH; k++)
          if (slot_v[k] && has_dst[k]) smap[dst[k]] <= pnew[k];
      end
      for (int k = 0; k < WIDTH; k++)
        if (ret_v[k]) rmap[ret_adst[k]] <= ret_pnew[k];
    end
  end

  for (genvar a = 0; a < ARCH_N; a++) begin : g_chk
    // R8: flush restores the speculative map from the committed map
    a_r8_map_restore: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (smap[a] == $past(rmap[a])));
  end
endmodule

// File: rtl/rn_rob.sv
module rn_rob import rn_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   fire,
  input  logic [WIDTH-1:0]       slot_v,
  input  robent_t [WIDTH-1:0]    alloc_ent,
  input  logic                   cmp_v,
  input  rtag_t                  cmp_tag,
  output rtag_t [WIDTH-1:0]      tag,
  output logic [RW:0]            space,
  output logic [WIDTH-1:0]       ret_v,
  output robent_t [WIDTH-1:0]    ret_ent
);
  logic [RW:0]       head, tail, occ, nret, nalloc;
  logic [ROB_N-1:0]  done;
  robent_t           ent [ROB_N];

  assign occ   = tail - head;
  assign space = (RW+1)'(ROB_N) - occ;

  always_comb begin
    nalloc = '0;
    for (int k = 0; k < WIDTH; k++) begin
      tag[k] = rtag_t'(tail[RW-1:0] + nalloc[RW-1:0]);
      nalloc = nalloc + (RW+1)'(slot_v[k]);
    end
  end

  always_comb begin
    logic ok;
    rtag_t idx;
    ok   = !flush;
    nret = '0;
    for (int k = 0; k < WIDTH; k++) begin
      idx = rtag_t'(head[RW-1:0] + rtag_t'(k));
      ok  = ok && (occ > (RW+1)'(k)) && done[idx];
      ret_v[k]   = ok;
      ret_ent[k] = ent[idx];
      nret = nret + (RW+1)'(ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      done <= '0;
    end else if (flush) begin
      tail <= head;
    end else begin
      head <= head + nret;
      if (fire) begin
        tail <= tail + nalloc;
        for (int k = 0; k < WIDTH; k++) if (slot_v[k]) done[tag[k]] <= 1'b0;
      end
      if (cmp_v) done[cmp_tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && !flush)
      for (int k = 0; k < WIDTH; k++) if (slot_v[k]) ent[tag[k]] <= alloc_ent[k];
  end

  // R5: occupancy never exceeds capacity
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (RW+1)'(ROB_N));
  // R8: flush leaves the buffer empty
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));
  // R6: a completion names an entry that is in flight
  a_r6_cmp_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_v && !flush) |-> ({1'b0, rtag_t'(cmp_tag - head[RW-1:0])} < occ));
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top import rn_pkg::*; (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WIDTH-1:0]           in_slot_v,
  input  logic [WIDTH-1:0]           in_has_dst,
  input  logic [WIDTH-1:0][AW-1:0]   in_src_a,
  input  logic [WIDTH-1:0][AW-1:0]   in_src_b,
  input  logic [WIDTH-1:0][AW-1:0]   in_dst,
  output logic [WIDTH-1:0][RW-1:0]   out_tag,
  output logic [WIDTH-1:0][PW-1:0]   out_psrc_a,
  output logic [WIDTH-1:0][PW-1:0]   out_psrc_b,
  output logic [WIDTH-1:0][PW-1:0]   out_pdst,
  output logic [WIDTH-1:0][PW-1:0]   out_pold,
  input  logic                       cmp_valid,
  input  logic [RW-1:0]              cmp_tag,
  input  logic                       flush,
  output logic [CW-1:0]              ret_cnt
);
  logic                       fire;
  logic [RW:0]                nvalid, space;
  logic [PW:0]                ndst, avail;
  logic [WIDTH-1:0]           take, ret_v, rel_v, map_ret_v;
  preg_t   [WIDTH-1:0]        pick, pnew, pold, rel_p, ret_pnew;
  areg_t   [WIDTH-1:0]        ret_adst;
  robent_t [WIDTH-1:0]        alloc_ent, ret_ent;
  rtag_t   [WIDTH-1:0]        tag;
  logic [PHYS_N-1:0]          keep_mask;

  always_comb begin
    nvalid = '0;
    ndst   = '0;
    for (int k = 0; k < WIDTH; k++) begin
      nvalid = nvalid + (RW+1)'(in_slot_v[k]);
      ndst   = ndst + (PW+1)'(in_slot_v[k] && in_has_dst[k]);
    end
  end

  assign in_ready = !flush && (nvalid <= space) && (ndst <= avail);
  assign fire     = in_valid && in_ready;

  // k-th destination slot takes the k-th pick of the pool
  always_comb begin
    logic [CW-1:0] r;
    r    = '0;
    take = '0;
    for (int k = 0; k < WIDTH; k++) begin
      pnew[k] = pick[r[CW-1:0]];
      if (in_slot_v[k] && in_has_dst[k]) begin
        take[r] = fire;
        r = r + 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      alloc_ent[k].has_dst = in_has_dst[k];
      alloc_ent[k].adst    = in_dst[k];
      alloc_ent[k].pnew    = pnew[k];
      alloc_ent[k].pold    = pold[k];
      rel_v[k]    = ret_v[k] && ret_ent[k].has_dst;
      rel_p[k]    = ret_ent[k].pold;
      ret_adst[k] = ret_ent[k].adst;
      ret_pnew[k] = ret_ent[k].pnew;
    end
  end
  assign map_ret_v = rel_v;

  rn_freelist u_free (
    .clk(clk), .rst_n(rst_n), .flush(flush), .keep_mask(keep_mask),
    .take(take), .rel_v(rel_v), .rel_p(rel_p), .pick(pick), .avail(avail)
  );

  rn_maptable u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .slot_v(in_slot_v), .has_dst(in_has_dst),
    .src_a(in_src_a), .src_b(in_src_b), .dst(in_dst), .pnew(pnew),
    .ret_v(map_ret_v), .ret_adst(ret_adst), .ret_pnew(ret_pnew),
    .psrc_a(out_psrc_a), .psrc_b(out_psrc_b), .pold(pold), .keep_mask(keep_mask)
  );

  rn_rob u_rob (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire), .slot_v(in_slot_v),
    .alloc_ent(alloc_ent), .cmp_v(cmp_valid), .cmp_tag(cmp_tag),
    .tag(tag), .space(space), .ret_v(ret_v), .ret_ent(ret_ent)
  );

  assign out_tag  = tag;
  assign out_pdst = pnew;
  assign out_pold = pold;

  always_comb begin
    ret_cnt = '0;
    for (int k = 0; k < WIDTH; k++) ret_cnt = ret_cnt + CW'(ret_v[k]);
  end

  // R5: nothing is accepted while a flush is in progress
  a_r5_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fire);
endmodule

// File: tb/sim_rn_rename_top.sv
module sim_rn_rename_top;
  import rn_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_slot_v = '0, in_has_dst = '0;
  logic [2:0][2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [2:0][4:0] out_tag;
  logic [2:0][6:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;
  logic cmp_valid = 1'b0;
  logic [4:0] cmp_tag = '0;
  logic flush = 1'b0;
  logic [1:0] ret_cnt;

  int total = 0, bad = 0;

  // bench model
  int smap[8], rmap[8];
  bit mfree[128];
  int rhead = 0, rtail = 0;
  bit mdone[32];
  bit mhas[32];
  int madst[32], mpnew[32], mpold[32];

  always #10 clk = ~clk;

  rn_rename_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_v(in_slot_v), .in_has_dst(in_has_dst), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .out_tag(out_tag),
    .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b), .out_pdst(out_pdst),
    .out_pold(out_pold), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .flush(flush), .ret_cnt(ret_cnt)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 8; a++) begin smap[a] = a; rmap[a] = a; end
    for (int i = 0; i < 128; i++) mfree[i] = (i >= 8);
    rhead = 0; rtail = 0;
    for (int i = 0; i < 32; i++) mdone[i] = 1'b0;
  endtask

  // evaluate the cycle's outputs against the model, then advance the model
  task automatic cyc();
    int occ, nv, nd, nf, exp_ret, pos;
    bit er, fire;
    int tmp[8];
    bit fr[128];
    int plist[3];
    int np;
    #1;
    occ = rtail - rhead;
    nv = 0; nd = 0; nf = 0;
    for (int k = 0; k < 3; k++) if (in_slot_v[k]) begin nv++; if (in_has_dst[k]) nd++; end
    for (int i = 0; i < 128; i++) if (mfree[i]) nf++;
    er = !flush && (nv <= 32 - occ) && (nd <= nf);
    chk(in_ready === er, "R5", int'(in_ready), int'(er));
    exp_ret = 0;
    if (!flush)
      for (int k = 0; k < 3; k++)
        if (occ > k && mdone[(rhead + k) % 32] && exp_ret == k) exp_ret++;
    chk(int'(ret_cnt) == exp_ret, "R6", int'(ret_cnt), exp_ret);
    fire = in_valid && er;
    tmp = smap; fr = mfree; pos = 0; np = 0;
    if (fire) begin
      for (int k = 0; k < 3; k++) begin
        if (in_slot_v[k]) begin
          int t, pd;
          t = (rtail + pos) % 32;
          chk(int'(out_tag[k]) == t, "R4", int'(out_tag[k]), t);
          chk(int'(out_psrc_a[k]) == tmp[in_src_a[k]], "R2", int'(out_psrc_a[k]), tmp[in_src_a[k]]);
          chk(int'(out_psrc_b[k]) == tmp[in_src_b[k]], "R2", int'(out_psrc_b[k]), tmp[in_src_b[k]]);
          mhas[t] = in_has_dst[k];
          madst[t] = in_dst[k];
          if (in_has_dst[k]) begin
            pd = -1;
            for (int i = 127; i >= 0; i--) if (fr[i]) pd = i;
            fr[pd] = 1'b0;
            chk(int'(out_pold[k]) == tmp[in_dst[k]], "R3", int'(out_pold[k]), tmp[in_dst[k]]);
            chk(int'(out_pdst[k]) == pd, "R3", int'(out_pdst[k]), pd);
            mpold[t] = tmp[in_dst[k]];
            mpnew[t] = pd;
            tmp[in_dst[k]] = pd;
            plist[np] = pd; np++;
          end
          pos++;
        end
      end
    end
    // advance model (R9: invalid slots contributed nothing above)
    if (flush) begin
      smap = rmap;
      for (int i = 0; i < 128; i++) mfree[i] = 1'b1;
      for (int a = 0; a < 8; a++) mfree[rmap[a]] = 1'b0;
      rtail = rhead;
    end else begin
      for (int r = 0; r < exp_ret; r++) begin
        int h;
        h = rhead % 32;
        if (mhas[h]) begin mfree[mpold[h]] = 1'b1; rmap[madst[h]] = mpnew[h]; end
        rhead++;
      end
      if (cmp_valid) mdone[cmp_tag] = 1'b1;
      if (fire) begin
        for (int k = 0; k < pos; k++) mdone[(rtail + k) % 32] = 1'b0;
        for (int k = 0; k < np; k++) mfree[plist[k]] = 1'b0;
        smap = tmp;
        rtail += pos;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_group(bit v, logic [2:0] sv, logic [2:0] hd);
    in_valid = v; in_slot_v = sv; in_has_dst = hd;
  endtask

  task automatic rand_group();
    in_valid = ($urandom % 10) < 7;
    in_slot_v = 3'($urandom);
    in_has_dst = 3'($urandom | $urandom);
    for (int k = 0; k < 3; k++) begin
      in_src_a[k] = 3'($urandom); in_src_b[k] = 3'($urandom); in_dst[k] = 3'($urandom);
    end
  endtask

  task automatic rand_cmp(int pct);
    int occ, idx;
    cmp_valid = 1'b0;
    occ = rtail - rhead;
    if (!flush && occ > 0 && int'($urandom % 100) < pct) begin
      idx = (rhead + int'($urandom % occ)) % 32;
      if (!mdone[idx]) begin cmp_valid = 1'b1; cmp_tag = 5'(idx); end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    #1;
    chk(ret_cnt == 2'd0, "R1", int'(ret_cnt), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(negedge clk);
    in_src_a[0] = 3'd5; in_src_b[0] = 3'd7; in_dst[0] = 3'd2;
    in_src_a[1] = 3'd0; in_src_b[1] = 3'd3; in_dst[1] = 3'd4;
    in_src_a[2] = 3'd6; in_src_b[2] = 3'd1; in_dst[2] = 3'd6;
    set_group(1'b1, 3'b111, 3'b111);
    #1;
    chk(out_psrc_a[0] == 7'd5, "R1", int'(out_psrc_a[0]), 5);
    chk(out_pdst[0] == 7'd8 && out_pdst[2] == 7'd10, "R1", int'(out_pdst[2]), 10);
    #1;
    cyc();
    // R2/R3: one register chained through all slots, with a hole (R9)
    in_dst[0] = 3'd1; in_src_a[1] = 3'd1; in_dst[1] = 3'd1;
    in_src_a[2] = 3'd1; in_src_b[2] = 3'd1; in_dst[2] = 3'd1;
    set_group(1'b1, 3'b111, 3'b111); cyc();
    set_group(1'b1, 3'b101, 3'b111); cyc();
    set_group(1'b1, 3'b110, 3'b010); cyc();
    // R5: fill the buffer with no completions
    for (int i = 0; i < 14; i++) begin rand_group(); set_group(1'b1, 3'b111, 3'b111); cyc(); end
    set_group(1'b1, 3'b001, 3'b001); cyc();
    set_group(1'b0, 3'b000, 3'b000);
    // R6: complete youngest first so commit waits for the head
    for (int i = rtail - 1; i >= rhead; i--) begin
      cmp_valid = 1'b1; cmp_tag = 5'(i % 32); cyc();
    end
    cmp_valid = 1'b0;
    while (rtail != rhead) cyc();
    // R8: flush after partial commit
    for (int i = 0; i < 40; i++) begin rand_group(); rand_cmp(50); cyc(); end
    cmp_valid = 1'b0; flush = 1'b1; rand_group(); cyc();
    flush = 1'b0;
    for (int i = 0; i < 6; i++) begin rand_group(); cyc(); end
    // random traffic with occasional flush (R7 reuse of returned registers)
    for (int i = 0; i < 4000; i++) begin
      flush = ($urandom % 100) < 1;
      rand_group();
      rand_cmp(75);
      cyc();
    end
    flush = 1'b0; cmp_valid = 1'b0; in_valid = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule